// File: doc/BRIEF.md
# Auto-Precharge Command Spacing Monitor for an Eight-Bank DRAM

This block sits beside a DRAM controller and watches the decoded command bus every clock. For each registered command it checks three things. It checks that the command keeps the minimum spacing from the most recent READ or WRITE that carried an auto-precharge request to a different bank. It checks that the command does not target a bank that is still working through its own auto-precharge sequence. It checks that a REFRESH or mode-register load is issued only while every bank is idle. When a command breaks a rule, the block raises a violation flag with a 3-bit code in the same cycle as the command.

The block also follows each bank through its life cycle: open after an ACTIVATE, then either closed by an explicit PRECHARGE or carried through an access phase and a precharge phase after an auto-precharge READ or WRITE. It reports, per bank, whether the bank is busy with auto precharge, whether it is in the precharge part of that sequence, and whether it is fully idle. CAS latency, burst length, write-to-read turnaround, write recovery and row-precharge time are static inputs given in clock cycles. A command that is flagged is treated as not executed and leaves all tracked state unchanged.

Top module: `ddr_ap_timing_checker`

## Requirements
- R1: After reset, no violation is reported, every bank reads idle, and no bank is busy or in its precharge phase.
- R2: While chip select is inactive (cs_n high), no command is registered and no violation is raised. Countdowns already running continue, and no other state changes.
- R3: After an accepted WRITE with auto precharge to bank n, a READ (either form) to a bank m other than n, issued fewer than (CL-1) + BL/2 + max(2, tWTR) cycles later, gives code 1.
- R4: After an accepted WRITE with auto precharge to bank n, a WRITE (either form) to another bank issued fewer than BL/2 cycles later gives code 1.
- R5: After an accepted READ with auto precharge to bank n, a READ to another bank issued fewer than BL/2 cycles later gives code 1. A WRITE to another bank issued fewer than BL/2 + 2 cycles later also gives code 1.
- R6: An ACTIVATE or PRECHARGE to a different bank is legal in the cycle right after an auto-precharge command (code 0).
- R7: A WRITE with auto precharge accepted at cycle t makes its bank busy from t+1. The precharge phase starts at t + (CL-1) + BL/2 + tWR. The bank is idle again tRP cycles after that.
- R8: A READ with auto precharge accepted at cycle t makes its bank busy from t+1. The precharge phase starts at t + BL/2. The bank is idle again at t + BL/2 + tRP.
- R9: Any ACTIVATE, READ, WRITE or PRECHARGE to a bank that is busy with auto precharge gives code 2. This takes priority over code 1.
- R10: A REFRESH or mode-register load while any bank is open or busy gives code 3. With all banks idle it gives code 0 and changes no state.
- R11: A command that gets a nonzero code does not change any bank state or spacing history.
- R12: ACTIVATE opens its bank (idle bit low). PRECHARGE closes it at once. A READ or WRITE without auto precharge leaves the bank open.
- R13: The command encodings are: 0 no-op, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH, 6 mode load, 7 reserved (treated as no-op). The code values are: 0 none, 1 cross-bank spacing, 2 busy bank, 3 not idle. `viol` is high exactly when the code is nonzero, in the cycle of the offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low; high means deselect |
| cmd | input | 3 | Decoded command (encoding in R13) |
| bank | input | 3 | Target bank address |
| ap | input | 1 | Auto-precharge request on READ/WRITE |
| cfg_cl | input | 4 | CAS latency in cycles (at least 2) |
| cfg_bl | input | 4 | Burst length in beats |
| cfg_twtr | input | 4 | Write-to-read turnaround in cycles |
| cfg_twr | input | 4 | Write recovery in cycles |
| cfg_trp | input | 4 | Row precharge time in cycles (at least 1) |
| viol | output | 1 | Violation flag for the current command |
| viol_code | output | 3 | Violation code for the current command |
| ap_busy | output | 8 | Per bank: busy with auto precharge |
| ap_prech | output | 8 | Per bank: in the precharge phase |
| bank_idle | output | 8 | Per bank: closed and not busy |

## Verification
The bench sweeps each spacing window across its boundary: one cycle inside the window, and the first cycle it is legal. It does this for the write-to-read window, where tWTR below 2 must be rounded up to 2. A design that used the raw tWTR, or an off-by-one age, would pass a READ one cycle early. It hits a busy bank with a command that also breaks spacing, so a design with the wrong priority would report code 1. It also issues an auto-precharge WRITE that is itself flagged, so a design that records flagged commands would show that bank as busy. Finally, long stretches of mixed traffic, including deselect cycles, are compared with a behavioural model every cycle. That comparison catches phase boundaries that are early or late by one cycle.

// File: rtl/ddr_apchk_pkg.sv
package ddr_apchk_pkg;

  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_ACT = 3'd1,
    C_RD  = 3'd2,
    C_WR  = 3'd3,
    C_PRE = 3'd4,
    C_REF = 3'd5,
    C_MRS = 3'd6,
    C_RSV = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    V_NONE    = 3'd0,
    V_SPACING = 3'd1,
    V_BUSY    = 3'd2,
    V_NOTIDLE = 3'd3
  } viol_e;

  // beats to clock cycles on a double data rate bus
  function automatic int half_burst(int bl);
    return bl / 2;
  endfunction

  // turnaround is never shorter than two cycles
  function automatic int wtr_eff(int twtr);
    return (twtr < 2) ? 2 : twtr;
  endfunction

  function automatic int wra_to_rd_gap(int cl, int bl, int twtr);
    return (cl - 1) + half_burst(bl) + wtr_eff(twtr);
  endfunction

  function automatic int rda_to_wr_gap(int bl);
    return half_burst(bl) + 2;
  endfunction

  // cycles from command to start of the precharge phase
  function automatic int rd_access(int bl);
    return half_burst(bl);
  endfunction

  function automatic int wr_access(int cl, int bl, int twr);
    return (cl - 1) + half_burst(bl) + twr;
  endfunction

endpackage

// File: rtl/ddr_apchk_spacing.sv
module ddr_apchk_spacing
  import ddr_apchk_pkg::*;
#(
  parameter int BW = 3,
  parameter int CW = 4,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  cmd_e          cmd,
  input  logic [BW-1:0] bank,
  input  logic          ap,
  input  logic [CW-1:0] cfg_cl,
  input  logic [CW-1:0] cfg_bl,
  input  logic [CW-1:0] cfg_twtr,
  output logic          spc_err
);

  typedef struct packed {
    logic          vld;
    logic [BW-1:0] bnk;
    logic [AW-1:0] age;
  } hist_t;

  localparam int NKIND = 2;   // 0: write with AP, 1: read with AP

  hist_t hist [NKIND];
  logic  rec  [NKIND];

  assign rec[0] = accept && ap && (cmd == C_WR);
  assign rec[1] = accept && ap && (cmd == C_RD);

  for (genvar k = 0; k < NKIND; k++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist[k] <= '0;
      end else if (rec[k]) begin
        hist[k].vld <= 1'b1;
        hist[k].bnk <= bank;
        hist[k].age <= AW'(1);
      end else if (hist[k].vld && hist[k].age != '1) begin
        hist[k].age <= hist[k].age + AW'(1);
      end
    end
  end

  int  half_c, wr_rd_c, rd_wr_c, wage, rage;
  logic wra_other, rda_other, wra_hit, rda_hit;

  always_comb begin
    half_c    = half_burst(int'(cfg_bl));
    wr_rd_c   = wra_to_rd_gap(int'(cfg_cl), int'(cfg_bl), int'(cfg_twtr));
    rd_wr_c   = rda_to_wr_gap(int'(cfg_bl));
    wage      = int'(hist[0].age);
    rage      = int'(hist[1].age);
    wra_other = hist[0].vld && (hist[0].bnk != bank);
    rda_other = hist[1].vld && (hist[1].bnk != bank);
    wra_hit   = wra_other &&
                (((cmd == C_RD) && (wage < wr_rd_c)) ||
                 ((cmd == C_WR) && (wage < half_c)));
    rda_hit   = rda_other &&
                (((cmd == C_RD) && (rage < half_c)) ||
                 ((cmd == C_WR) && (rage < rd_wr_c)));
    spc_err   = wra_hit || rda_hit;
  end

endmodule

// File: rtl/ddr_apchk_bank.sv
module ddr_apchk_bank
  import ddr_apchk_pkg::*;
#(
  parameter int CW = 4,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  cmd_e          cmd,
  input  logic          ap,
  input  logic [TW-1:0] load_rd,
  input  logic [TW-1:0] load_wr,
  input  logic [CW-1:0] cfg_trp,
  output logic          busy,
  output logic          prech,
  output logic          idle
);

  logic [TW-1:0] cnt;
  logic          open_q;
  logic          rw_cmd;

  assign rw_cmd = (cmd == C_RD) || (cmd == C_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      open_q <= 1'b0;
    end else begin
      if (cnt != '0) cnt <= cnt - TW'(1);
      if (hit) begin
        if (rw_cmd && ap) begin
          open_q <= 1'b0;
          cnt    <= (cmd == C_RD) ? load_rd : load_wr;
        end else if (rw_cmd || cmd == C_ACT) begin
          open_q <= 1'b1;
        end else if (cmd == C_PRE) begin
          open_q <= 1'b0;
        end
      end
    end
  end

  // cnt holds cycles left until idle; the last tRP of them are precharge
  assign busy  = (cnt != '0);
  assign prech = busy && (int'(cnt) <= int'(cfg_trp));
  assign idle  = !open_q && !busy;

endmodule

// File: rtl/ddr_ap_timing_checker.sv
module ddr_ap_timing_checker
  import ddr_apchk_pkg::*;
#(
  parameter int NB = 8,
  parameter int CW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic [2:0]            cmd,
  input  logic [$clog2(NB)-1:0] bank,
  input  logic                  ap,
  input  logic [CW-1:0]         cfg_cl,
  input  logic [CW-1:0]         cfg_bl,
  input  logic [CW-1:0]         cfg_twtr,
  input  logic [CW-1:0]         cfg_twr,
  input  logic [CW-1:0]         cfg_trp,
  output logic                  viol,
  output logic [2:0]            viol_code,
  output logic [NB-1:0]         ap_busy,
  output logic [NB-1:0]         ap_prech,
  output logic [NB-1:0]         bank_idle
);

  localparam int BW = $clog2(NB);
  localparam int TW = CW + 2;
  localparam int AW = TW;

  cmd_e  c;
  viol_e code;
  logic  cmd_valid, is_global_cmd, tgt_busy, all_idle, spc_err, accept;
  logic [TW-1:0] load_rd, load_wr;

  assign c             = cmd_e'(cmd);
  assign cmd_valid     = !cs_n && (c != C_NOP) && (c != C_RSV);
  assign is_global_cmd = (c == C_REF) || (c == C_MRS);
  assign tgt_busy      = ap_busy[bank];
  assign all_idle      = &bank_idle;
  assign accept        = cmd_valid && (code == V_NONE);

  assign load_rd = TW'(rd_access(int'(cfg_bl)) + int'(cfg_trp) - 1);
  assign load_wr = TW'(wr_access(int'(cfg_cl), int'(cfg_bl), int'(cfg_twr))
                       + int'(cfg_trp) - 1);

  always_comb begin
    code = V_NONE;
    if (cmd_valid) begin
      if (is_global_cmd) begin
        if (!all_idle) code = V_NOTIDLE;
      end else if (tgt_busy) begin
        code = V_BUSY;
      end else if (spc_err) begin
        code = V_SPACING;
      end
    end
  end

  assign viol_code = code;
  assign viol      = (code != V_NONE);

  ddr_apchk_spacing #(.BW(BW), .CW(CW), .AW(AW)) u_spacing (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .cmd      (c),
    .bank     (bank),
    .ap       (ap),
    .cfg_cl   (cfg_cl),
    .cfg_bl   (cfg_bl),
    .cfg_twtr (cfg_twtr),
    .spc_err  (spc_err)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit;
    assign hit = accept && !is_global_cmd && (bank == BW'(i));
    ddr_apchk_bank #(.CW(CW), .TW(TW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .cmd     (c),
      .ap      (ap),
      .load_rd (load_rd),
      .load_wr (load_wr),
      .cfg_trp (cfg_trp),
      .busy    (ap_busy[i]),
      .prech   (ap_prech[i]),
      .idle    (bank_idle[i])
    );
  end

endmodule

// File: rtl/ddr_ap_timing_checker_chk.sv
module ddr_ap_timing_checker_chk #(
  parameter int NB = 8,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic [2:0]    cmd,
  input logic [BW-1:0] bank,
  input logic          ap,
  input logic          viol,
  input logic [2:0]    viol_code,
  input logic [NB-1:0] ap_busy,
  input logic [NB-1:0] bank_idle
);

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !viol);

  // R2
  deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && ap_busy == '0) |=> $stable(bank_idle));

  // R10
  notidle_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (cmd == 3'd5 || cmd == 3'd6) && !(&bank_idle)) |-> viol_code == 3'd3);

  // R9
  busy_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cmd >= 3'd1 && cmd <= 3'd4 && ap_busy[bank]) |-> viol_code == 3'd2);

  // R7
  ap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (cmd == 3'd2 || cmd == 3'd3) && ap && !viol) |=> ap_busy[$past(bank)]);

  // R12
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cmd == 3'd1 && !viol) |=> !bank_idle[$past(bank)]);

endmodule

bind ddr_ap_timing_checker ddr_ap_timing_checker_chk #(.NB(NB), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .cmd       (cmd),
  .bank      (bank),
  .ap        (ap),
  .viol      (viol),
  .viol_code (viol_code),
  .ap_busy   (ap_busy),
  .bank_idle (bank_idle)
);

// File: tb/ddr_ap_timing_checker_bench.sv
`timescale 1ns/1ps
module ddr_ap_timing_checker_bench;

  localparam int CL = 4, BL = 8, TWTR = 1, TWR = 3, TRP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [2:0] bank = 3'd0;
  logic ap = 1'b0;
  logic viol;
  logic [2:0] viol_code;
  logic [7:0] ap_busy, ap_prech, bank_idle;

  always #2.5 clk = ~clk;

  ddr_ap_timing_checker u_ddr_ap_timing_checker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .bank(bank), .ap(ap),
    .cfg_cl(4'(CL)), .cfg_bl(4'(BL)), .cfg_twtr(4'(TWTR)),
    .cfg_twr(4'(TWR)), .cfg_trp(4'(TRP)),
    .viol(viol), .viol_code(viol_code), .ap_busy(ap_busy),
    .ap_prech(ap_prech), .bank_idle(bank_idle)
  );

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;
  int idle_at[8], pre_at[8];
  bit is_open[8];
  int wra_c = -1000, wra_b = -1, rda_c = -1000, rda_b = -1;

  // legal distances restated from the requirements
  function automatic int need_wr_to_rd();
    int t = (TWTR > 2) ? TWTR : 2;
    return t + BL / 2 + CL - 1;
  endfunction

  task automatic step(input logic cs, input int c_in, input int b_in,
                      input logic ap_in, input string tag);
    int exp_code;
    logic [7:0] eb, ep, ei;
    bit valid, all_idle, spc;
    @(negedge clk);
    cs_n = cs; cmd = 3'(c_in); bank = 3'(b_in); ap = ap_in;
    #1;
    for (int b = 0; b < 8; b++) begin
      eb[b] = cyc < idle_at[b];
      ep[b] = eb[b] && cyc >= pre_at[b];
      ei[b] = !is_open[b] && !eb[b];
    end
    all_idle = (ei == 8'hFF);
    valid = !cs && c_in >= 1 && c_in <= 6;
    exp_code = 0;
    if (valid) begin
      if (c_in == 5 || c_in == 6) begin
        if (!all_idle) exp_code = 3;
      end else if (eb[b_in]) begin
        exp_code = 2;
      end else begin
        spc = 0;
        if (wra_b >= 0 && wra_b != b_in) begin
          if (c_in == 2 && cyc - wra_c < need_wr_to_rd()) spc = 1;
          if (c_in == 3 && cyc - wra_c < BL / 2) spc = 1;
        end
        if (rda_b >= 0 && rda_b != b_in) begin
          if (c_in == 2 && cyc - rda_c < BL / 2) spc = 1;
          if (c_in == 3 && cyc - rda_c < BL / 2 + 2) spc = 1;
        end
        if (spc) exp_code = 1;
      end
    end
    vectors++;
    if (int'(viol_code) != exp_code || viol != (exp_code != 0)) begin
      fails++;
      $display("FAIL %s cyc %0d: code %0d viol %0b, expected code %0d",
               tag, cyc, viol_code, viol, exp_code);
    end
    if (ap_busy != eb || ap_prech != ep || bank_idle != ei) begin
      fails++;
      $display("FAIL %s cyc %0d: busy %h prech %h idle %h, expected %h %h %h",
               tag, cyc, ap_busy, ap_prech, bank_idle, eb, ep, ei);
    end
    if (valid && exp_code == 0) begin
      case (c_in)
        1: is_open[b_in] = 1;
        4: is_open[b_in] = 0;
        2, 3: begin
          if (ap_in) begin
            int acc = (c_in == 2) ? BL / 2 : CL - 1 + BL / 2 + TWR;
            is_open[b_in] = 0;
            pre_at[b_in]  = cyc + acc;
            idle_at[b_in] = cyc + acc + TRP;
            if (c_in == 3) begin wra_c = cyc; wra_b = b_in; end
            else           begin rda_c = cyc; rda_b = b_in; end
          end else begin
            is_open[b_in] = 1;
          end
        end
        default: ;
      endcase
    end
    cyc++;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 8; b++) begin idle_at[b] = 0; pre_at[b] = 0; is_open[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, "R1"); step(0, 7, 0, 0, "R1");
    step(0, 1, 0, 0, "R12"); step(0, 2, 0, 0, "R12");
    step(0, 5, 0, 0, "R10"); step(0, 6, 0, 0, "R13");
    step(0, 4, 0, 0, "R12");
    step(0, 5, 0, 0, "R10"); step(0, 6, 0, 0, "R10");
    step(0, 1, 1, 0, "R12"); step(0, 1, 2, 0, "R12");
    // write with AP on bank 1
    step(0, 3, 1, 1, "R7");
    step(0, 4, 3, 0, "R6");
    step(0, 3, 2, 0, "R4");
    step(0, 2, 2, 0, "R3");
    step(0, 3, 1, 0, "R9");
    step(1, 2, 1, 1, "R2"); step(1, 5, 0, 0, "R2");
    step(0, 2, 3, 0, "R3"); step(0, 2, 3, 0, "R3"); step(0, 2, 3, 0, "R3");
    step(0, 3, 2, 0, "R4");
    repeat (6) step(0, 0, 0, 0, "R7");
    // read with AP on bank 2
    step(0, 2, 2, 1, "R8");
    step(0, 1, 5, 0, "R6");
    step(0, 2, 3, 0, "R5");
    step(0, 3, 4, 1, "R11");
    step(0, 3, 3, 0, "R5");
    step(0, 1, 2, 0, "R9");
    step(0, 2, 3, 0, "R5");
    step(0, 3, 3, 0, "R5");
    step(0, 5, 0, 0, "R10");
    repeat (4) step(0, 0, 0, 0, "R11");
    step(0, 4, 1, 0, "R12"); step(0, 4, 2, 0, "R12"); step(0, 4, 3, 0, "R12");
    step(0, 4, 5, 0, "R12");
    step(0, 5, 0, 0, "R10");
    for (int i = 0; i < 500; i++)
      step($urandom_range(0, 5) == 0, int'($urandom_range(0, 6)),
           int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R11");
    finish_run();
  end

endmodule